// File: doc/BRIEF.md
# Self-Locking Line Scrambler and Descrambler

This block holds a 23-bit self-synchronising shift register that either descrambles the bit stream recovered from detected line symbols or, fed with a constant one, regenerates the sequence a far-end scrambler produces when it scrambles all ones. Detected symbols arrive as a 2-bit code. They are turned into one bit per symbol in two-level line mode and into two bits per symbol in four-level line mode. The register therefore advances once or twice per symbol. A configuration input picks the feedback polynomial for a central-office unit or a remote-terminal unit.

While the lock-enable input is high, an internal sequencer aligns the register with the far end during start-up. It first descrambles 23 received bits, which loads the far-end state. It then runs the register as a scrambler for 127 bits and compares every generated bit with the received bit. If any bit differs it goes back to the load step. If all 127 bits match it sets a sticky lock flag and keeps regenerating the far-end sequence. The flag drives an interrupt through an enable. When lock-enable is dropped, the block goes back to plain descrambling.

Top module: `selflock_scrambler`

## Requirements
- R1: After a synchronous reset, bit_vld, lock_flag and irq are all 0, and the shift register holds all zeros.
- R2: The symbol code means 2'b00 = -3, 2'b01 = -1, 2'b10 = +1 and 2'b11 = +3. In two-level mode (four_lvl=0) a symbol gives one bit: -3 gives 0 and +3 gives 1. The result appears on bit_vld/bit_out two cycles after the sym_vld cycle.
- R3: In four-level mode a symbol gives two bits in consecutive cycles, the sign bit first and the magnitude bit second: -3 gives 00, -1 gives 01, +1 gives 11 and +3 gives 10. Symbols are spaced at least two cycles apart in this mode.
- R4: With lock_en low, each received bit d leaves as d ^ s[tap] ^ s[22], and d is shifted into s[0]. As a result, a stream that a far-end scrambler with the same polynomial produced from a zero state is recovered exactly from reset onward.
- R5: co_mode=1 selects the polynomial x^23+x^5+1 (tap s[4]). co_mode=0 selects x^23+x^18+1 (tap s[17]).
- R6: After lock_en rises, the next 23 received bits are descrambled as in R4.
- R7: The following 127 bits run the register as a scrambler with a constant 1 input. The output is the generated bit 1 ^ s[tap] ^ s[22], and that bit is shifted into s[0].
- R8: If all 127 generated bits equal the received bits, lock_flag becomes 1 within the cycle that outputs the 150th bit after lock start. The register then keeps running as a scrambler, so its output keeps matching the received line.
- R9: If any of the 127 bits differs, lock_flag stays 0 and a new 23-bit load step begins with the next bit. A later clean attempt then locks 150 bits after its own start.
- R10: lock_flag stays set until a cycle with irq_clr=1 clears it. irq is lock_flag AND irq_en.
- R11: Dropping lock_en returns the block to the descrambling of R4 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_en | input | 1 | Runs the lock sequencer while high |
| co_mode | input | 1 | 1 = central-office taps, 0 = remote-terminal taps |
| four_lvl | input | 1 | 1 = four-level symbols, 0 = two-level symbols |
| sym_vld | input | 1 | Detected symbol strobe |
| sym_code | input | 2 | Detected symbol: 00=-3, 01=-1, 10=+1, 11=+3 |
| irq_en | input | 1 | Interrupt enable (mask) |
| irq_clr | input | 1 | Clears the lock flag |
| bit_vld | output | 1 | Output bit strobe |
| bit_out | output | 1 | Descrambled or regenerated bit |
| lock_flag | output | 1 | Sticky lock-achieved flag |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest situation to reach is a failed check phase followed by a clean retry. The register must fall back to loading at exactly the right bit, and the next attempt must align its own 150-bit count. The bench gets there by flipping a single line bit in the middle of the first check phase while its far-end model keeps scrambling ones. It then restarts its bit count at the 150th bit and expects the retry's descrambled ones, then the line bits, and a lock exactly 150 bits later. It also probes the lock boundary on both sides, one bit before and at the 150th bit.

// File: rtl/slk_pkg.sv
package slk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_CHECK  = 2'd2,
    ST_LOCKED = 2'd3
  } lock_st_t;
endpackage

// File: rtl/slk_symconv.sv
module slk_symconv (
  input  logic       clk,
  input  logic       rst,
  input  logic       four_lvl,
  input  logic       sym_vld,
  input  logic [1:0] sym_code,
  output logic       bit_vld,
  output logic       bit_val
);
  logic pend, pend_bit;

  // Sign bit = code[1]; magnitude = code[1]^code[0] gives 00,01,11,10.
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_vld  <= 1'b0;
      bit_val  <= 1'b0;
      pend     <= 1'b0;
      pend_bit <= 1'b0;
    end else if (sym_vld) begin
      bit_vld  <= 1'b1;
      bit_val  <= sym_code[1];
      pend     <= four_lvl;
      pend_bit <= sym_code[1] ^ sym_code[0];
    end else if (pend) begin
      bit_vld  <= 1'b1;
      bit_val  <= pend_bit;
      pend     <= 1'b0;
    end else begin
      bit_vld  <= 1'b0;
    end
  end

  p_two_lvl_r2: assert property (@(posedge clk) disable iff (rst)
    sym_vld && !four_lvl |=> bit_vld && bit_val == $past(sym_code[1]));
  p_four_lvl_r3: assert property (@(posedge clk) disable iff (rst)
    sym_vld && four_lvl |=> bit_vld ##1 bit_vld);
endmodule

// File: rtl/slk_lfsr.sv
module slk_lfsr #(
  parameter int LEN    = 23,
  parameter int TAP_CO = 5,
  parameter int TAP_RT = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic scr_mode,
  input  logic co_mode,
  input  logic din,
  output logic dout,
  output logic gen_bit
);
  logic [LEN-1:0] sr;
  logic fb, shin;

  always_comb begin
    fb      = (co_mode ? sr[TAP_CO-1] : sr[TAP_RT-1]) ^ sr[LEN-1];
    gen_bit = ~fb;
    dout    = scr_mode ? gen_bit : (din ^ fb);
    shin    = scr_mode ? gen_bit : din;
  end

  always_ff @(posedge clk) begin
    if (rst)       sr <= '0;
    else if (step) sr <= {sr[LEN-2:0], shin};
  end

  p_desc_shift_r4: assert property (@(posedge clk) disable iff (rst)
    step && !scr_mode |=> sr[0] == $past(din));
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(sr));
endmodule

// File: rtl/slk_lock_fsm.sv
module slk_lock_fsm
  import slk_pkg::*;
#(
  parameter int LOAD_BITS  = 23,
  parameter int CHECK_BITS = 127,
  parameter int CNT_W      = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic lock_en,
  input  logic step,
  input  logic din,
  input  logic gen_bit,
  output logic scr_mode,
  output logic lock_ok
);
  localparam logic [CNT_W-1:0] LOAD_LAST = CNT_W'(LOAD_BITS - 1);
  localparam logic [CNT_W-1:0] CHK_LAST  = CNT_W'(CHECK_BITS - 1);

  lock_st_t         st;
  logic [CNT_W-1:0] cnt;
  logic             miss, miss_n;

  always_comb begin
    miss_n   = miss | (din ^ gen_bit);
    scr_mode = (st == ST_CHECK) || (st == ST_LOCKED);
    lock_ok  = step && (st == ST_CHECK) && (cnt == CHK_LAST) && !miss_n;
  end

  always_ff @(posedge clk) begin
    if (rst || !lock_en) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      miss <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          st  <= ST_LOAD;
          cnt <= '0;
        end
        ST_LOAD: if (step) begin
          if (cnt == LOAD_LAST) begin
            st   <= ST_CHECK;
            cnt  <= '0;
            miss <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
        ST_CHECK: if (step) begin
          if (cnt == CHK_LAST) begin
            st   <= miss_n ? ST_LOAD : ST_LOCKED;
            cnt  <= '0;
            miss <= 1'b0;
          end else begin
            cnt  <= cnt + 1'b1;
            miss <= miss_n;
          end
        end
        default: st <= ST_LOCKED;
      endcase
    end
  end

  p_load_bound_r6: assert property (@(posedge clk) disable iff (rst)
    st == ST_LOAD |-> cnt <= LOAD_LAST);
  p_check_bound_r7: assert property (@(posedge clk) disable iff (rst)
    st == ST_CHECK |-> cnt <= CHK_LAST);
  p_lock_entry_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(st == ST_LOCKED) |-> $past(st) == ST_CHECK);
  p_drop_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !lock_en |=> st == ST_IDLE);
endmodule

// File: rtl/selflock_scrambler.sv
module selflock_scrambler #(
  parameter int LEN        = 23,
  parameter int TAP_CO     = 5,
  parameter int TAP_RT     = 18,
  parameter int LOAD_BITS  = 23,
  parameter int CHECK_BITS = 127,
  parameter int CNT_W      = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lock_en,
  input  logic       co_mode,
  input  logic       four_lvl,
  input  logic       sym_vld,
  input  logic [1:0] sym_code,
  input  logic       irq_en,
  input  logic       irq_clr,
  output logic       bit_vld,
  output logic       bit_out,
  output logic       lock_flag,
  output logic       irq
);
  logic c_vld, c_bit, scr_mode, dout, gen_bit, lock_ok;

  slk_symconv u_conv (
    .clk(clk), .rst(rst), .four_lvl(four_lvl), .sym_vld(sym_vld),
    .sym_code(sym_code), .bit_vld(c_vld), .bit_val(c_bit)
  );

  slk_lfsr #(.LEN(LEN), .TAP_CO(TAP_CO), .TAP_RT(TAP_RT)) u_lfsr (
    .clk(clk), .rst(rst), .step(c_vld), .scr_mode(scr_mode),
    .co_mode(co_mode), .din(c_bit), .dout(dout), .gen_bit(gen_bit)
  );

  slk_lock_fsm #(.LOAD_BITS(LOAD_BITS), .CHECK_BITS(CHECK_BITS),
                 .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .lock_en(lock_en), .step(c_vld), .din(c_bit),
    .gen_bit(gen_bit), .scr_mode(scr_mode), .lock_ok(lock_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_vld   <= 1'b0;
      bit_out   <= 1'b0;
      lock_flag <= 1'b0;
    end else begin
      bit_vld <= c_vld;
      bit_out <= dout;
      if (lock_ok)      lock_flag <= 1'b1;
      else if (irq_clr) lock_flag <= 1'b0;
    end
  end

  assign irq = lock_flag & irq_en;

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    lock_flag && !irq_clr |=> lock_flag);
  p_flag_needs_lock_r9: assert property (@(posedge clk) disable iff (rst)
    !lock_en |=> !$rose(lock_flag));
endmodule

// File: tb/test_selflock_scrambler.sv
module test_selflock_scrambler;
  logic clk = 1'b0, rst = 1'b1;
  logic lock_en = 0, co_mode = 1, four_lvl = 0, sym_vld = 0, irq_en = 0, irq_clr = 0;
  logic [1:0] sym_code = 2'b00;
  logic bit_vld, bit_out, lock_flag, irq;

  always #5 clk = ~clk;

  selflock_scrambler i_selflock_scrambler (
    .clk(clk), .rst(rst), .lock_en(lock_en), .co_mode(co_mode),
    .four_lvl(four_lvl), .sym_vld(sym_vld), .sym_code(sym_code),
    .irq_en(irq_en), .irq_clr(irq_clr), .bit_vld(bit_vld),
    .bit_out(bit_out), .lock_flag(lock_flag), .irq(irq)
  );

  typedef struct packed { logic care; logic val; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;
  string tag = "R1";
  logic [22:0] fe;
  int kind = 0;   // 0: expect data, 1: lock tracking, 2: ignore
  int nlock = 0;

  task automatic chk(input string r, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s got %0b expected %0b", r, act, exp);
    end
  endtask

  // Far-end scrambler model, same polynomial as selected by co_mode.
  task automatic fe_scr(input logic d, output logic l);
    logic fb;
    fb = (co_mode ? fe[4] : fe[17]) ^ fe[22];
    l  = d ^ fb;
    fe = {fe[21:0], l};
  endtask

  task automatic push_exp(input logic d, input logic l);
    exp_t e;
    e.care = (kind != 2);
    e.val  = (kind == 0 || (kind == 1 && nlock < 23)) ? d : l;
    nlock++;
    q.push_back(e);
  endtask

  task automatic put_sym(input logic [1:0] c);
    @(negedge clk); sym_vld = 1'b1; sym_code = c;
    @(negedge clk); sym_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic send2(input logic d, input logic flip);
    logic l;
    fe_scr(d, l);
    push_exp(d, l);
    put_sym((l ^ flip) ? 2'b11 : 2'b00);
  endtask

  task automatic send4(input logic d0, input logic d1);
    logic l0, l1;
    fe_scr(d0, l0); push_exp(d0, l0);
    fe_scr(d1, l1); push_exp(d1, l1);
    put_sym({l0, l0 ^ l1});
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; lock_en = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0; fe = '0; kind = 0; nlock = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pops expected items as the design emits bits.
  always @(negedge clk) begin
    if (!rst && bit_vld) begin
      if (q.size() == 0) chk({tag, " extra bit"}, 1'b1, 1'b0);
      else begin
        exp_t e;
        e = q.pop_front();
        if (e.care) chk({tag, " bit"}, bit_out, e.val);
      end
    end
  end

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog got timeout expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    fe = '0;
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1 bit_vld", bit_vld, 1'b0);
    chk("R1 lock_flag", lock_flag, 1'b0);
    chk("R1 irq", irq, 1'b0);
    do_reset();
    chk("R1 bit_vld after reset", bit_vld, 1'b0);

    // R2 R4 R5: two-level descramble, central-office taps
    tag = "R2_R4_R5_co"; co_mode = 1; four_lvl = 0;
    for (int i = 0; i < 60; i++) send2(1'($urandom % 2), 1'b0);
    settle();

    // R5: remote-terminal taps
    do_reset();
    tag = "R5_rt"; co_mode = 0;
    for (int i = 0; i < 60; i++) send2(1'($urandom % 2), 1'b0);
    settle();

    // R3: four-level
    do_reset();
    tag = "R3_four"; co_mode = 1; four_lvl = 1;
    for (int i = 0; i < 40; i++) send4(1'($urandom % 2), 1'($urandom % 2));
    settle();
    four_lvl = 0;

    // R6 R7 R8: successful lock
    do_reset();
    tag = "R4_warm"; co_mode = 1;
    for (int i = 0; i < 30; i++) send2(1'($urandom % 2), 1'b0);
    @(negedge clk); lock_en = 1; repeat (2) @(negedge clk);
    tag = "R6_R7_lock"; kind = 1; nlock = 0;
    for (int i = 0; i < 149; i++) send2(1'b1, 1'b0);
    settle();
    chk("R8 no lock at bit 149", lock_flag, 1'b0);
    send2(1'b1, 1'b0);
    settle();
    chk("R8 lock at bit 150", lock_flag, 1'b1);
    chk("R10 irq masked", irq, 1'b0);
    tag = "R8_replica";
    for (int i = 0; i < 40; i++) send2(1'b1, 1'b0);
    settle();
    irq_en = 1; @(negedge clk);
    chk("R10 irq enabled", irq, 1'b1);
    chk("R10 flag sticky", lock_flag, 1'b1);
    irq_clr = 1; @(negedge clk); irq_clr = 0; @(negedge clk);
    chk("R10 flag cleared", lock_flag, 1'b0);
    chk("R10 irq cleared", irq, 1'b0);
    lock_en = 0; @(negedge clk);
    tag = "R11_back_to_descramble"; kind = 0;
    for (int i = 0; i < 40; i++) send2(1'($urandom % 2), 1'b0);
    settle();
    chk("R11 no relock", lock_flag, 1'b0);

    // R9: failed attempt, then retry locks
    do_reset();
    co_mode = 0; irq_en = 1;
    for (int i = 0; i < 30; i++) send2(1'b1, 1'b0);
    @(negedge clk); lock_en = 1; repeat (2) @(negedge clk);
    tag = "R9_fail"; kind = 2; nlock = 0;
    for (int i = 0; i < 150; i++) send2(1'b1, i == 60);
    settle();
    chk("R9 no lock after bad attempt", lock_flag, 1'b0);
    chk("R9 irq low", irq, 1'b0);
    tag = "R9_retry"; kind = 1; nlock = 0;
    for (int i = 0; i < 149; i++) send2(1'b1, 1'b0);
    settle();
    chk("R9 retry not yet locked", lock_flag, 1'b0);
    send2(1'b1, 1'b0);
    settle();
    chk("R9 retry locked", lock_flag, 1'b1);
    chk("R10 irq on retry lock", irq, 1'b1);

    settle();
    chk("R2 all bits emitted", 1'(q.size() == 0), 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule